// File: doc/BRIEF.md
# Multi-Lane Receive Skew Release Controller

This block decides when a group of per-lane elastic buffers on a multi-lane serial receiver may start being read. Each lane begins writing its buffer when its first payload character arrives. Lanes arrive with different latencies, so the earliest lane fills while the later lanes catch up. The controller issues one read enable that is common to all lanes. That enable rises at a multiframe boundary plus a programmable offset. Because every lane is then read out together, the arrival skew between them is removed.

The controller keeps a fill count for each lane, starting from that lane's start-of-data flag. If the earliest lane would hold more characters than the configured buffer depth before the release, the controller raises a sticky deskew error. A boundary pulse that comes while any lane has not yet started is skipped, and the release waits for a later boundary. The data storage, character decoding and the boundary counter are outside this block.

Top module: `rx_skew_release`

## Requirements
- R1: While reset is asserted and directly after it, `rd_en` and `deskew_err` are 0.
- R2: With `rel_offset` = 0, `rd_en` is 1 in the same cycle as the first accepted `mf_pulse`. A pulse is accepted when every lane's `lane_start` bit was sampled high in an earlier cycle.
- R3: With `rel_offset` = k > 0, `rd_en` rises exactly k cycles after the accepted `mf_pulse`. Pulses that arrive during that wait are ignored. `rel_offset` must be below the multiframe length `MF_LEN`.
- R4: An `mf_pulse` that arrives while any lane has not started does not release. The release happens at the next pulse that meets the R2 condition.
- R5: Once `rd_en` is 1, it stays 1 until reset, whatever happens on `mf_pulse`.
- R6: Suppose a lane's start flag is first high in cycle s and the release happens in cycle f. That lane then holds f-s characters at release. Its count stops at release. `deskew_err` is set only if f-s is greater than `buf_depth` for the earliest lane. In that case it rises in cycle s+`buf_depth`+2.
- R7: `deskew_err` is sticky. When `clr_err` is high in a cycle, the flag is 0 in the next cycle. If the overflow condition still holds before release, the flag is set again one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_err | input | 1 | Synchronous clear of the deskew error |
| lane_start | input | LANES | Per-lane start-of-data flag; high from the first payload character onward |
| mf_pulse | input | 1 | One-cycle multiframe boundary pulse |
| rel_offset | input | OFS_W | Release delay in link clocks after the boundary |
| buf_depth | input | DEPTH_W | Elastic buffer depth in entries |
| rd_en | output | 1 | Common buffer read enable |
| deskew_err | output | 1 | Sticky lane deskew error |

## Verification
The hardest situation to reach from the ports is an overflow that comes only from the release offset. In that case the lanes are close enough together, but the offset pushes the release past the point where the earliest lane exceeds the buffer depth. The stimulus holds the lane start cycles and the boundary fixed and changes only the offset, which gives one pass case and one error case. Two further cases probe the exact limit where f-s equals the depth and where it equals the depth plus one. The error clear is also exercised both before and after release, so that the re-raise behaviour becomes visible.

// File: rtl/rx_skew_release.sv
module rx_skew_release #(
  parameter int LANES   = 4,
  parameter int DEPTH_W = 4,
  parameter int OFS_W   = 5,
  parameter int MF_LEN  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_err,
  input  logic [LANES-1:0]   lane_start,
  input  logic               mf_pulse,
  input  logic [OFS_W-1:0]   rel_offset,
  input  logic [DEPTH_W-1:0] buf_depth,
  output logic               rd_en,
  output logic               deskew_err
);

  localparam int CW = DEPTH_W + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [LANES-1:0] started;
  logic [LANES-1:0] over;
  logic [CW-1:0]    fill [LANES];
  logic             released, pending;
  logic [OFS_W-1:0] ocnt;

  wire all_started = &started;
  wire arm  = mf_pulse && all_started && !released && !pending;
  wire fire = (arm && rel_offset == '0) || (pending && ocnt == '0);

  assign rd_en = released | fire;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        started[i] <= 1'b0;
        fill[i]    <= '0;
      end else begin
        started[i] <= started[i] | lane_start[i];
        if (!started[i] && lane_start[i])
          fill[i] <= CW'(1);
        else if (started[i] && !released && !fire && fill[i] != CMAX)
          fill[i] <= fill[i] + CW'(1);
      end
    end

    assign over[i] = started[i] && (fill[i] > {1'b0, buf_depth});

    AST_FILL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      released |=> $stable(fill[i])); // R6
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      ocnt     <= '0;
      released <= 1'b0;
    end else begin
      released <= released | fire;
      if (arm && rel_offset != '0) begin
        pending <= 1'b1;
        ocnt    <= rel_offset - OFS_W'(1);
      end else if (pending) begin
        if (ocnt == '0) pending <= 1'b0;
        else            ocnt    <= ocnt - OFS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     deskew_err <= 1'b0;
    else if (clr_err)               deskew_err <= 1'b0;
    else if (|over && !released)    deskew_err <= 1'b1;
  end

  AST_RD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_en); // R5
  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_en) |-> &started); // R4
  AST_OFS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mf_pulse |-> (int'(rel_offset) < MF_LEN)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    deskew_err && !clr_err |=> deskew_err); // R7
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> !deskew_err); // R7

endmodule

// File: tb/test_rx_skew_release.sv
`timescale 1ns/1ps
module test_rx_skew_release;
  localparam int LANES = 4;
  localparam int N = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_err = 1'b0;
  logic [LANES-1:0] lane_start = '0;
  logic mf_pulse = 1'b0;
  logic [4:0] rel_offset = '0;
  logic [3:0] buf_depth = 4'd8;
  logic rd_en, deskew_err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {bit rd; bit er; int cyc; string rtag; string etag;} exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  rx_skew_release i_rx_skew_release (
    .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .lane_start(lane_start),
    .mf_pulse(mf_pulse), .rel_offset(rel_offset), .buf_depth(buf_depth),
    .rd_en(rd_en), .deskew_err(deskew_err)
  );

  task automatic check(bit act, bit exp, string tag, int cyc);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(rd_en, e.rd, e.rtag, e.cyc);
      check(deskew_err, e.er, e.etag, e.cyc);
    end
  end

  task automatic run(int s0, int s1, int s2, int s3, int p0, int per, int ofs,
                     int d, int clr, string rtag, string etag);
    int s[4];
    int smax, smin, f, e;
    s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
    smax = s0; smin = s0;
    for (int i = 1; i < 4; i++) begin
      if (s[i] > smax) smax = s[i];
      if (s[i] < smin) smin = s[i];
    end
    f = -1;
    for (int j = p0; j < N; j += per)
      if (f < 0 && smax < j) f = j + ofs;
    e = (f >= 0 && f - smin > d) ? smin + d + 2 : -1;

    @(negedge clk);
    rst_n = 1'b0; lane_start = '0; mf_pulse = 1'b0; clr_err = 1'b0;
    rel_offset = 5'(ofs); buf_depth = 4'(d);
    @(negedge clk);
    #2;
    check(rd_en, 1'b0, "R1 rd_en in reset", 0);
    check(deskew_err, 1'b0, "R1 deskew_err in reset", 0);
    rst_n = 1'b1;
    for (int j = 0; j < N; j++) begin
      exp_t x;
      bit ex;
      @(negedge clk);
      for (int i = 0; i < 4; i++) lane_start[i] = (j >= s[i]);
      mf_pulse = (j >= p0) && ((j - p0) % per == 0);
      clr_err  = (j == clr);
      ex = (e >= 0) && (j >= e);
      if (clr >= 0 && ex && j >= clr + 1)
        ex = (clr + 1 <= f) ? (j != clr + 1) : 1'b0;
      x.rd = (f >= 0) && (j >= f);
      x.er = ex;
      x.cyc = j;
      x.rtag = rtag;
      x.etag = etag;
      q.push_back(x);
    end
    @(negedge clk);
    mf_pulse = 1'b0; clr_err = 1'b0;
    #6;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R2: zero offset, release at boundary, skew 3 within depth 8
    run(2, 3, 5, 4, 8, 16, 0, 8, -1, "R2 zero-offset release", "R6 no error in range");
    // R3: offset 3 pushes release to 11, earliest lane holds 9 > 8
    run(2, 3, 5, 4, 8, 16, 3, 8, -1, "R3 offset release", "R6 offset overflow");
    // R4: first boundary skipped while lane 3 is late
    run(1, 1, 1, 9, 4, 8, 0, 15, -1, "R4 held release", "R6 no error");
    // R6: exact limit, f-s equals depth
    run(3, 3, 3, 3, 4, 16, 4, 5, -1, "R3 offset 4", "R6 at limit");
    // R6: one past the limit
    run(3, 3, 3, 3, 4, 16, 4, 4, -1, "R3 offset 4", "R6 one over limit");
    // R7: clear after release stays clear; R5 later pulses keep rd_en
    run(2, 3, 5, 4, 8, 4, 3, 8, 20, "R5 sticky release", "R7 clear after release");
    // R7: clear before release, error re-raises
    run(1, 1, 1, 1, 20, 16, 0, 3, 10, "R2 late boundary", "R7 clear then re-raise");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule